// File: doc/BRIEF.md
# Phase-Stepped Subset Processor

This block is a 32-bit load/store processor for a small integer subset (and, or, add, sub, slt, lw, sw, beq). It carries each instruction through five phases in a fixed sequence: fetch, decode, execute, memory, writeback. It moves forward by one phase for each one-cycle pulse on `step`. Between pulses every latched value holds still, so a debug harness can inspect the machine after any phase.

The block contains the program counter, a 32-entry register file, the main decoder with ALU control, the ALU, and two small word-addressed memories, one for instructions and one for data. A plain preload port fills both memories before a program runs. The outputs show the current phase, the PC, the latched ALU result and zero flag, and the latched memory read data.

Top module: `stepcpu_top`

## Requirements
- R1: A synchronous reset sets the PC to 0, the phase to fetch (code 0), every register and every debug view to 0.
- R2: Phase codes are fetch=0, decode=1, execute=2, memory=3, writeback=4. Each cycle with `step` high moves one phase forward, and writeback wraps to fetch. With `step` low the phase and the PC hold.
- R3: The instruction memory is read only in fetch. Rewriting the fetched word later in the same instruction does not change the instruction that executes.
- R4: R-type instructions have opcode 0 and take rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. The funct codes are add 0x20, sub 0x22, and 0x24, or 0x25 and slt 0x2A. slt compares as signed and gives 1 or 0. The execute phase places the result on `dbg_alu`, and `dbg_zero` is 1 exactly when that result is 0.
- R5: lw (opcode 0x23) and sw (opcode 0x2B) address data word (rs + sign-extended imm[15:0]) / 4. After the memory phase of a lw, the loaded word appears on `dbg_rdata`. sw stores the rt value.
- R6: Writeback writes the memory data for lw and the ALU result for R-type instructions. The destination is rd for R-type and rt for lw. sw and beq write no register.
- R7: beq (opcode 0x04) compares rs and rt by subtraction. When they are equal, the next PC is PC+4+(sign-extended imm << 2). Otherwise it is PC+4.
- R8: The PC changes only in the cycle that completes writeback.
- R9: Register 0 always reads as zero, and writes to it are dropped.
- R10: An unsupported opcode, or an R-type word with an unsupported funct, changes no register and no data word. It only advances the PC by 4.
- R11: While `ld_en` is high, `ld_data` is written to word `ld_addr` of the data memory when `ld_dmem`=1, or of the instruction memory when `ld_dmem`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance one phase when high for a cycle |
| ld_en | input | 1 | Preload write enable |
| ld_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| ld_addr | input | LAW | Preload word index |
| ld_data | input | 32 | Preload word |
| phase_o | output | 3 | Current phase code |
| dbg_pc | output | 32 | Program counter |
| dbg_alu | output | 32 | Latched ALU result |
| dbg_zero | output | 1 | Latched ALU zero flag |
| dbg_rdata | output | 32 | Latched data-memory read word |

## Verification
The assertions assume that `step` is a clean synchronous level that is sampled at every edge. They also assume that preload writes to the data memory do not coincide with a memory phase that stores. The stimulus performs every preload before the program starts stepping. The one exception is the instruction-memory rewrite used to test R3, which never touches the data memory. All instruction addresses stay inside the instruction memory, and every data address is word-aligned, which the design expects and does not check.

// File: rtl/stepcpu_pkg.sv
package stepcpu_pkg;
  typedef enum logic [2:0] {
    PH_FETCH = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC = 3'd2,
    PH_MEM = 3'd3,
    PH_WB = 3'd4
  } phase_e;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW = 6'h23;
  localparam logic [5:0] OP_SW = 6'h2B;
  localparam logic [5:0] OP_BEQ = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [3:0] AL_AND = 4'b0000;
  localparam logic [3:0] AL_OR = 4'b0001;
  localparam logic [3:0] AL_ADD = 4'b0010;
  localparam logic [3:0] AL_SUB = 4'b0110;
  localparam logic [3:0] AL_SLT = 4'b0111;

  typedef struct packed {
    logic       dst_is_rd;
    logic       use_imm;
    logic       wb_from_mem;
    logic       wr_reg;
    logic       rd_mem;
    logic       wr_mem;
    logic       is_branch;
    logic [3:0] alu_fn;
  } ctrl_t;
endpackage

// File: rtl/stepcpu_ctrl.sv
module stepcpu_ctrl
  import stepcpu_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctl
);
  logic [5:0] op;
  logic [5:0] fn;
  assign op = instr[31:26];
  assign fn = instr[5:0];

  always_comb begin
    ctl = '0;
    unique case (op)
      OP_RTYPE: begin
        ctl.dst_is_rd = 1'b1;
        ctl.wr_reg = 1'b1;
        unique case (fn)
          FN_ADD: ctl.alu_fn = AL_ADD;
          FN_SUB: ctl.alu_fn = AL_SUB;
          FN_AND: ctl.alu_fn = AL_AND;
          FN_OR: ctl.alu_fn = AL_OR;
          FN_SLT: ctl.alu_fn = AL_SLT;
          default: begin
            ctl.wr_reg = 1'b0;
            ctl.dst_is_rd = 1'b0;
          end
        endcase
      end
      OP_LW: begin
        ctl.use_imm = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.wr_reg = 1'b1;
        ctl.rd_mem = 1'b1;
        ctl.alu_fn = AL_ADD;
      end
      OP_SW: begin
        ctl.use_imm = 1'b1;
        ctl.wr_mem = 1'b1;
        ctl.alu_fn = AL_ADD;
      end
      OP_BEQ: begin
        ctl.is_branch = 1'b1;
        ctl.alu_fn = AL_SUB;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/stepcpu_alu.sv
module stepcpu_alu
  import stepcpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (fn)
      AL_AND: y = a & b;
      AL_OR: y = a | b;
      AL_ADD: y = a + b;
      AL_SUB: y = a - b;
      AL_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/stepcpu_regfile.sv
module stepcpu_regfile #(
  parameter int W = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RAW-1:0] ra,
  input  logic [RAW-1:0] rb,
  output logic [W-1:0]   qa,
  output logic [W-1:0]   qb,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [W-1:0]   wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];

  AST_ZERO_REG_QUIET: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> (regs[0] == '0)) else $error("r0 written"); // R9
endmodule

// File: rtl/stepcpu_top.sv
module stepcpu_top
  import stepcpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           ld_en,
  input  logic           ld_dmem,
  input  logic [LAW-1:0] ld_addr,
  input  logic [31:0]    ld_data,
  output logic [2:0]     phase_o,
  output logic [31:0]    dbg_pc,
  output logic [31:0]    dbg_alu,
  output logic           dbg_zero,
  output logic [31:0]    dbg_rdata
);
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  phase_e      phase;
  logic [31:0] pc, ir, a_q, b_q, alu_q, mdr_q;
  logic        zero_q;
  logic [4:0]  dst_q;
  ctrl_t       ctl_d, ctl_q;

  logic [31:0] rf_qa, rf_qb, alu_b, alu_y, imm_ext, pc_plus4, pc_branch;
  logic        alu_z, rf_we;
  logic        take_branch;

  stepcpu_ctrl u_ctrl (.instr(ir), .ctl(ctl_d));

  stepcpu_regfile #(.W(32), .NREG(32)) u_rf (
    .clk(clk), .rst(rst),
    .ra(ir[25:21]), .rb(ir[20:16]), .qa(rf_qa), .qb(rf_qb),
    .we(rf_we), .wa(dst_q), .wd(ctl_q.wb_from_mem ? mdr_q : alu_q)
  );

  assign imm_ext = {{16{ir[15]}}, ir[15:0]};
  assign alu_b = ctl_q.use_imm ? imm_ext : b_q;

  stepcpu_alu #(.W(32)) u_alu (.a(a_q), .b(alu_b), .fn(ctl_q.alu_fn), .y(alu_y), .zero(alu_z));

  assign pc_plus4 = pc + 32'd4;
  assign pc_branch = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign take_branch = ctl_q.is_branch && zero_q;
  assign rf_we = step && phase == PH_WB && ctl_q.wr_reg;

  // preload ports
  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_dmem) dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (!rst && step && phase == PH_MEM && ctl_q.wr_mem)
      dmem[alu_q[DAW+1:2]] <= b_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
      pc <= '0;
      ir <= '0;
      a_q <= '0;
      b_q <= '0;
      alu_q <= '0;
      zero_q <= 1'b0;
      mdr_q <= '0;
      dst_q <= '0;
      ctl_q <= '0;
    end else if (step) begin
      unique case (phase)
        PH_FETCH: begin
          ir <= imem[pc[IAW+1:2]];
          phase <= PH_DECODE;
        end
        PH_DECODE: begin
          a_q <= rf_qa;
          b_q <= rf_qb;
          ctl_q <= ctl_d;
          dst_q <= ctl_d.dst_is_rd ? ir[15:11] : ir[20:16];
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          alu_q <= alu_y;
          zero_q <= alu_z;
          phase <= PH_MEM;
        end
        PH_MEM: begin
          if (ctl_q.rd_mem) mdr_q <= dmem[alu_q[DAW+1:2]];
          phase <= PH_WB;
        end
        default: begin
          pc <= take_branch ? pc_branch : pc_plus4;
          phase <= PH_FETCH;
        end
      endcase
    end
  end

  wire unused_bits = ^{pc[1:0], pc[31:IAW+2], alu_q[1:0], alu_q[31:DAW+2], ld_addr};

  assign phase_o = phase;
  assign dbg_pc = pc;
  assign dbg_alu = alu_q;
  assign dbg_zero = zero_q;
  assign dbg_rdata = mdr_q;

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step && phase != PH_WB) |=> (3'(phase) == 3'($past(phase)) + 3'd1)) else $error("phase order"); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && phase == PH_WB) |=> (phase == PH_FETCH)) else $error("phase wrap"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(phase) && $stable(pc))) else $error("moved without step"); // R2
  AST_PC_AT_WB_ONLY: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_WB) |=> $stable(pc)) else $error("pc moved early"); // R8
  AST_IR_FETCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_FETCH) |=> $stable(ir)) else $error("ir changed"); // R3
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    (step && phase == PH_WB && !take_branch) |=> (pc == $past(pc) + 32'd4)) else $error("pc+4"); // R7
  AST_MEM_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MEM) |-> !(ctl_q.rd_mem && ctl_q.wr_mem)) else $error("read and write"); // R5
endmodule

// File: tb/stepcpu_top_test.sv
module stepcpu_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step = 1'b0;
  logic ld_en = 1'b0;
  logic ld_dmem = 1'b0;
  logic [5:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [2:0] phase_o;
  logic [31:0] dbg_pc, dbg_alu, dbg_rdata;
  logic dbg_zero;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stepcpu_top uut (
    .clk(clk), .rst(rst), .step(step), .ld_en(ld_en), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .phase_o(phase_o), .dbg_pc(dbg_pc),
    .dbg_alu(dbg_alu), .dbg_zero(dbg_zero), .dbg_rdata(dbg_rdata)
  );

  function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic dm, input int addr, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_dmem = dm; ld_addr = 6'(addr); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
  endtask

  // one full instruction with optional checks of ALU, zero flag, read data, next pc
  task automatic run(input string req, input logic [31:0] ealu, input bit calu,
                     input logic ez, input bit cz, input logic [31:0] erd, input bit crd,
                     input logic [31:0] epc);
    logic [31:0] pc0;
    pc0 = dbg_pc;
    pulse(); pulse(); pulse();
    if (calu) check(req, dbg_alu, ealu);
    if (cz) check(req, 32'(dbg_zero), 32'(ez));
    pulse();
    if (crd) check(req, dbg_rdata, erd);
    check("R8", dbg_pc, pc0);
    pulse();
    check(req, dbg_pc, epc);
  endtask

  task automatic t_reset();
    check("R1", 32'(phase_o), 32'd0);
    check("R1", dbg_pc, 32'd0);
    check("R1", dbg_alu, 32'd0);
    check("R1", dbg_rdata, 32'd0);
  endtask

  task automatic t_preload();
    // R11: data words and the program
    load(1, 0, 32'd5);
    load(1, 1, 32'hFFFF_FFFD);
    load(1, 2, 32'h0F0F_00FF);
    load(0, 0, itype(6'h23, 0, 1, 0));
    load(0, 1, itype(6'h23, 0, 2, 4));
    load(0, 2, itype(6'h23, 0, 3, 8));
    load(0, 3, rtype(1, 2, 4, 6'h20));
    load(0, 4, rtype(1, 2, 5, 6'h22));
    load(0, 5, rtype(3, 1, 6, 6'h24));
    load(0, 6, rtype(3, 1, 7, 6'h25));
    load(0, 7, rtype(2, 1, 8, 6'h2A));
    load(0, 8, rtype(1, 2, 9, 6'h2A));
    load(0, 9, itype(6'h2B, 0, 4, 12));
    load(0, 10, itype(6'h23, 0, 10, 12));
    load(0, 11, rtype(1, 1, 0, 6'h20));
    load(0, 12, rtype(0, 0, 11, 6'h20));
    load(0, 13, itype(6'h3F, 2, 1, 0));
    load(0, 14, rtype(2, 2, 1, 6'h00));
    load(0, 15, rtype(1, 0, 12, 6'h20));
    load(0, 16, itype(6'h04, 1, 2, 5));
    load(0, 17, itype(6'h04, 1, 1, 2));
    load(0, 20, rtype(1, 1, 13, 6'h20));
    load(0, 21, itype(6'h04, 0, 0, -22));
    load(0, 0, itype(6'h23, 0, 1, 0));
  endtask

  task automatic t_phase_walk();
    // R2: no step holds, each step advances one code
    repeat (3) @(negedge clk);
    check("R2", 32'(phase_o), 32'd0);
    for (int k = 1; k <= 4; k++) begin
      pulse();
      check("R2", 32'(phase_o), 32'(k));
      repeat (2) @(negedge clk);
      check("R2", 32'(phase_o), 32'(k));
    end
    pulse();
    check("R2", 32'(phase_o), 32'd0);
    check("R2", dbg_pc, 32'd4);
    check("R5", dbg_rdata, 32'd5);
  endtask

  task automatic t_loads();
    run("R5", 32'd4, 1, 0, 0, 32'hFFFF_FFFD, 1, 32'd8);
    run("R5", 32'd8, 1, 0, 0, 32'h0F0F_00FF, 1, 32'd12);
  endtask

  task automatic t_alu();
    run("R4", 32'd2, 1, 0, 1, 0, 0, 32'd16);
    run("R4", 32'd8, 1, 0, 0, 0, 0, 32'd20);
    run("R4", 32'd5, 1, 0, 0, 0, 0, 32'd24);
    run("R4", 32'h0F0F_00FF, 1, 0, 0, 0, 0, 32'd28);
    run("R4", 32'd1, 1, 0, 1, 0, 0, 32'd32);
    run("R4", 32'd0, 1, 1, 1, 0, 0, 32'd36);
  endtask

  task automatic t_store();
    run("R5", 32'd12, 1, 0, 0, 0, 0, 32'd40);
    run("R6", 32'd12, 1, 0, 0, 32'd2, 1, 32'd44);
  endtask

  task automatic t_zero_reg();
    run("R9", 32'd10, 1, 0, 0, 0, 0, 32'd48);
    run("R9", 32'd0, 1, 1, 1, 0, 0, 32'd52);
  endtask

  task automatic t_unsupported();
    run("R10", 0, 0, 0, 0, 0, 0, 32'd56);
    run("R10", 0, 0, 0, 0, 0, 0, 32'd60);
    run("R10", 32'd5, 1, 0, 0, 0, 0, 32'd64);
  endtask

  task automatic t_branch();
    run("R7", 32'd8, 1, 0, 1, 0, 0, 32'd68);
    run("R7", 32'd0, 1, 1, 1, 0, 0, 32'd80);
  endtask

  task automatic t_fetch_once();
    // R3: fetch word 20, then overwrite it before execute
    pulse();
    load(0, 20, rtype(2, 2, 13, 6'h20));
    pulse(); pulse();
    check("R3", dbg_alu, 32'd10);
    pulse(); pulse();
    check("R3", dbg_pc, 32'd84);
    // R6: the rd destination holds its value; backward beq with r13 untouched
    run("R7", 32'd0, 1, 1, 1, 0, 0, 32'd0);
  endtask

  task automatic t_reset_again();
    pulse(); pulse();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1", dbg_pc, 32'd0);
    check("R1", 32'(phase_o), 32'd0);
    // registers cleared: lw r1 shows address 0, add r4 r1 r2 then reads zeros
    run("R1", 32'd0, 1, 1, 1, 32'd5, 1, 32'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_preload();
    t_phase_walk();
    t_loads();
    t_alu();
    t_store();
    t_zero_reg();
    t_unsupported();
    t_branch();
    t_fetch_once();
    t_reset_again();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule